// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Flag Register

This block performs one integer operation per clock on two operands, either 8 or 16 bits wide, and keeps the resulting condition codes in a 16-bit flag register. Ten operations are supported: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment, decrement and compare. The add-with-carry and subtract-with-borrow operations take their carry input from the stored carry flag. The registered result and the flag register are both outputs of the block.

Six status flags are produced: carry, parity, auxiliary carry, zero, sign and overflow. Three control flags share the same register: trap (single-step), interrupt enable and direction (string addresses count down when set). No arithmetic operation changes the control flags. Each control flag has its own set and clear inputs.

A caller presents an operation with `op_valid` high and sees the result and flags one cycle later. Compare updates only the flags. Increment and decrement leave the carry flag as it was.

Top module: `flag_alu`

## Requirements
- R1: While reset is asserted, and after it is released, `result` reads 16'h0000 and `flags` reads 16'h0002.
- R2: An accepted operation (`op_valid`=1, valid code) latches its result one cycle later. The codes are 0 add, 1 add+CF, 2 sub, 3 sub-CF, 4 AND, 5 OR, 6 XOR, 7 increment, 8 decrement and 9 compare. Operands are truncated to the selected width, and in byte mode (`word_mode`=0) result bits 15:8 are zero.
- R3: Carry (bit 0) is the carry out of the top bit for additions and the borrow into the top bit for subtractions. The top bit is bit 7 in byte mode and bit 15 in word mode.
- R4: Overflow (bit 11) is set when the two's-complement result at the selected width falls outside the signed range.
- R5: Zero (bit 6) is set when the width-truncated result is zero. Sign (bit 7) copies the result's top bit. Parity (bit 2) is set when result bits 7:0 hold an even number of ones.
- R6: Auxiliary carry (bit 4) is the carry or borrow out of bit 3 for arithmetic operations.
- R7: AND, OR and XOR clear the carry, overflow and auxiliary carry flags.
- R8: Increment and decrement leave the carry flag unchanged.
- R9: Compare updates the status flags exactly as subtract does, and leaves `result` unchanged.
- R10: `ctl_set[i]` sets and `ctl_clr[i]` clears control flag i on the next edge, with set winning when both are high. The mapping is i=0 trap (bit 8), i=1 interrupt enable (bit 9) and i=2 direction (bit 10). No operation alters these flags.
- R11: With `op_valid` low, or with a code from 10 to 15, `result` and all status flags keep their values.
- R12: Flag bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation code (see R2) |
| word_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| ctl_set | input | 3 | Set strobes for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear strobes for the same control flags |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag register |

## Verification
Properties checked on every cycle cover the following:
- the fixed bits of the flag register;
- carry being held across increment and decrement;
- the result being held across compare, idle cycles and invalid codes;
- the upper byte being zero after byte operations;
- logical operations clearing carry and overflow;
- the control-flag set, clear and hold behaviour.

Whether carry, borrow, overflow, auxiliary carry, parity and sign are numerically correct can only be shown by the bench. Its behavioural model computes these flags from signed and unsigned integer arithmetic. The bench drives directed boundary operands, such as 7FFF+1, FF+1, 0-1 and a borrow from bit 3, followed by a long run of random operations in both widths.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_CMP = 4'd9
  } alu_op_e;

  localparam int FB_CARRY  = 0;
  localparam int FB_PARITY = 2;
  localparam int FB_AUX    = 4;
  localparam int FB_ZERO   = 6;
  localparam int FB_SIGN   = 7;
  localparam int FB_CTL0   = 8;
  localparam int FB_OVF    = 11;
  localparam int N_CTL     = 3;

  localparam logic [15:0] FLAG_FIXED_MASK = 16'hF02A;
  localparam logic [15:0] FLAG_FIXED_VAL  = 16'h0002;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic          word,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cf_in,
  output logic [DW-1:0] res,
  output stat_t         st,
  output logic          op_ok,
  output logic          wr_res,
  output logic          keep_cf
);

  localparam int BW = DW / 2;

  logic [DW-1:0] msk, am, bm, bsel, lg, axr;
  logic [DW:0]   arith;
  logic          cin, is_sub, is_logic;
  logic          a_msb, b_msb, r_msb;

  assign msk = word ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
  assign am  = a & msk;
  assign bm  = b & msk;

  always_comb begin
    bsel     = bm;
    cin      = 1'b0;
    is_sub   = 1'b0;
    is_logic = 1'b0;
    lg       = '0;
    unique case (op)
      OP_ADC: cin = cf_in;
      OP_SUB, OP_CMP: is_sub = 1'b1;
      OP_SBB: begin is_sub = 1'b1; cin = cf_in; end
      OP_AND: begin is_logic = 1'b1; lg = am & bm; end
      OP_OR:  begin is_logic = 1'b1; lg = am | bm; end
      OP_XOR: begin is_logic = 1'b1; lg = am ^ bm; end
      OP_INC: bsel = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin bsel = {{(DW-1){1'b0}}, 1'b1}; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign arith = is_sub ? ({1'b0, am} - {1'b0, bsel} - {{DW{1'b0}}, cin})
                        : ({1'b0, am} + {1'b0, bsel} + {{DW{1'b0}}, cin});

  assign res = (is_logic ? lg : arith[DW-1:0]) & msk;
  assign axr = am ^ bsel ^ arith[DW-1:0];

  assign a_msb = word ? am[DW-1]   : am[BW-1];
  assign b_msb = word ? bsel[DW-1] : bsel[BW-1];
  assign r_msb = word ? res[DW-1]  : res[BW-1];

  always_comb begin
    st.pf = ~^res[7:0];
    st.zf = (res == '0);
    st.sf = r_msb;
    if (is_logic) begin
      st.cf = 1'b0;
      st.af = 1'b0;
      st.of = 1'b0;
    end else begin
      st.cf = word ? arith[DW] : arith[BW];
      st.af = axr[4];
      st.of = is_sub ? ((a_msb != b_msb) && (r_msb != a_msb))
                     : ((a_msb == b_msb) && (r_msb != a_msb));
    end
  end

  assign op_ok   = (op <= OP_CMP);
  assign wr_res  = (op != OP_CMP);
  assign keep_cf = (op == OP_INC) || (op == OP_DEC);

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_stat,
  input  logic             keep_cf,
  input  stat_t            st,
  input  logic [N_CTL-1:0] ctl_set,
  input  logic [N_CTL-1:0] ctl_clr,
  output logic [15:0]      flags
);

  stat_t            stat_q, stat_n;
  logic [N_CTL-1:0] ctl_q, ctl_n;

  always_comb begin
    stat_n = stat_q;
    if (upd_stat) begin
      stat_n = st;
      if (keep_cf) stat_n.cf = stat_q.cf;
    end
  end

  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    always_comb begin
      ctl_n[g] = ctl_q[g];
      if (ctl_set[g])      ctl_n[g] = 1'b1;
      else if (ctl_clr[g]) ctl_n[g] = 1'b0;
    end

    p_ctl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_set[g] |=> flags[FB_CTL0+g]);
    p_ctl_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_clr[g] && !ctl_set[g]) |=> !flags[FB_CTL0+g]);
    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clr[g] && !ctl_set[g]) |=> $stable(flags[FB_CTL0+g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      stat_q <= stat_n;
      ctl_q  <= ctl_n;
    end
  end

  always_comb begin
    flags            = FLAG_FIXED_VAL;
    flags[FB_CARRY]  = stat_q.cf;
    flags[FB_PARITY] = stat_q.pf;
    flags[FB_AUX]    = stat_q.af;
    flags[FB_ZERO]   = stat_q.zf;
    flags[FB_SIGN]   = stat_q.sf;
    flags[FB_OVF]    = stat_q.of;
    flags[FB_CTL0 +: N_CTL] = ctl_q;
  end

  p_fixed_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & FLAG_FIXED_MASK) == FLAG_FIXED_VAL);
  p_keep_cf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stat && keep_cf) |=> (flags[FB_CARRY] == $past(flags[FB_CARRY])));
  p_stat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stat |=> $stable({flags[FB_OVF], flags[7:0]}));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic        word_mode,
  input  logic [15:0] opa,
  input  logic [15:0] opb,
  input  logic [2:0]  ctl_set,
  input  logic [2:0]  ctl_clr,
  output logic [15:0] result,
  output logic [15:0] flags
);

  localparam int DW = 16;

  logic [DW-1:0] res_c, res_q, res_n;
  stat_t         st_c;
  logic          op_ok, wr_res, keep_cf, accept, res_en;

  alu_core #(.DW(DW)) u_core (
    .op      (op_code),
    .word    (word_mode),
    .a       (opa),
    .b       (opb),
    .cf_in   (flags[FB_CARRY]),
    .res     (res_c),
    .st      (st_c),
    .op_ok   (op_ok),
    .wr_res  (wr_res),
    .keep_cf (keep_cf)
  );

  assign accept = op_valid && op_ok;
  assign res_en = accept && wr_res;

  flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_stat (accept),
    .keep_cf  (keep_cf),
    .st       (st_c),
    .ctl_set  (ctl_set),
    .ctl_clr  (ctl_clr),
    .flags    (flags)
  );

  always_comb begin
    res_n = res_q;
    if (res_en) res_n = res_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_n;
  end

  assign result = res_q;

  p_cmp_keeps_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> $stable(result));
  p_idle_keeps_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > OP_CMP) |=> $stable(result));
  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !word_mode && op_code < OP_CMP) |=> (result[15:8] == 8'h00));
  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
    |=> (!flags[FB_CARRY] && !flags[FB_OVF] && !flags[FB_AUX]));

endmodule

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        word_mode;
  logic [15:0] opa, opb;
  logic [2:0]  ctl_set, ctl_clr;
  logic [15:0] result, flags;

  int total = 0;
  int bad   = 0;
  int exp_fl;
  int exp_rs;

  always #5 clk = ~clk;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .word_mode(word_mode), .opa(opa), .opb(opb), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .result(result), .flags(flags)
  );

  // Behavioural model of one accepted operation.
  task automatic model_op(input int op, input bit w, input int a, input int b);
    int mask = w ? 'hFFFF : 'hFF;
    int half = w ? 'h8000 : 'h80;
    int am = a & mask;
    int bm = b & mask;
    int c  = exp_fl & 1;
    int t = 0, r = 0, sa, sb, sr = 0, ones = 0;
    int cf = 0, af = 0, of = 0, zf, sf, pf;
    bit arith = 1, sub = 0, wr = 1, kc = 0;
    if (op > 9) return;
    case (op)
      0: c = 0;
      2: begin sub = 1; c = 0; end
      3: sub = 1;
      4, 5, 6: arith = 0;
      7: begin bm = 1; c = 0; kc = 1; end
      8: begin bm = 1; c = 0; sub = 1; kc = 1; end
      9: begin sub = 1; c = 0; wr = 0; end
      default: ;
    endcase
    sa = (am >= half) ? am - 2*half : am;
    sb = (bm >= half) ? bm - 2*half : bm;
    if (arith) begin
      if (sub) begin
        t = am - bm - c; cf = (t < 0);
        af = (((am & 15) - (bm & 15) - c) < 0);
        sr = sa - sb - c;
      end else begin
        t = am + bm + c; cf = (t > mask);
        af = (((am & 15) + (bm & 15) + c) > 15);
        sr = sa + sb + c;
      end
      of = (sr >= half) || (sr < -half);
      r = t & mask;
    end else begin
      r = (op == 4) ? (am & bm) : (op == 5) ? (am | bm) : (am ^ bm);
    end
    if (kc) cf = exp_fl & 1;
    zf = (r == 0);
    sf = ((r & half) != 0);
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    pf = ((ones % 2) == 0);
    exp_fl = (exp_fl & 'h0700) | 2 | cf | (pf << 2) | (af << 4) | (zf << 6)
           | (sf << 7) | (of << 11);
    if (wr) exp_rs = r;
  endtask

  task automatic check(input string tag);
    total++;
    if (result !== exp_rs[15:0] || flags !== exp_fl[15:0]) begin
      bad++;
      $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
               tag, result, flags, exp_rs[15:0], exp_fl[15:0]);
    end
  endtask

  // One clock: inputs applied at the falling edge, checked at the next one.
  task automatic cyc(input bit v, input int op, input bit w, input int a,
                     input int b, input int s, input int cl, input string tag);
    op_valid = v; op_code = op[3:0]; word_mode = w;
    opa = a[15:0]; opb = b[15:0]; ctl_set = s[2:0]; ctl_clr = cl[2:0];
    @(posedge clk);
    if (v) model_op(op, w, a, b);
    for (int i = 0; i < 3; i++) begin
      if (s[i])       exp_fl |= (1 << (8 + i));
      else if (cl[i]) exp_fl &= ~(1 << (8 + i));
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 0; op_code = 0; word_mode = 0;
    opa = 0; opb = 0; ctl_set = 0; ctl_clr = 0;
    exp_fl = 'h0002; exp_rs = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    cyc(1, 0, 1, 'h7FFF, 'h0001, 0, 0, "R4 word add overflow, R5 sign");
    cyc(1, 0, 0, 'h00FF, 'h0001, 0, 0, "R3 byte carry, R5 zero, R6 aux");
    cyc(1, 1, 0, 'h0010, 'h0020, 0, 0, "R2 add with stored carry");
    cyc(1, 2, 0, 'h0000, 'h0001, 0, 0, "R3 byte borrow, R5 parity");
    cyc(1, 3, 1, 'h1000, 'h0001, 0, 0, "R2 sub with stored borrow, R6 bit3 borrow");
    cyc(1, 2, 1, 'h8000, 'h0001, 0, 0, "R4 word sub overflow");
    cyc(1, 2, 0, 'h0012, 'h0345, 0, 0, "R2 byte truncation");
    cyc(1, 0, 1, 'hFFFF, 'hFFFF, 0, 0, "R3 word carry");
    cyc(1, 4, 1, 'hF0F0, 'h0FF0, 0, 0, "R7 AND clears carry");
    cyc(1, 0, 1, 'h7FFF, 'h7FFF, 0, 0, "R4 set overflow again");
    cyc(1, 6, 0, 'h00AA, 'h0055, 0, 0, "R7 XOR clears overflow");
    cyc(1, 5, 1, 'h0000, 'h0000, 0, 0, "R7 OR zero result");
    cyc(1, 0, 0, 'h0080, 'h0080, 0, 0, "R3 set carry before inc");
    cyc(1, 7, 0, 'h00FF, 'h0000, 0, 0, "R8 inc wraps, carry kept");
    cyc(1, 8, 1, 'h0000, 'h0000, 0, 0, "R8 dec wraps, carry kept");
    cyc(1, 9, 1, 'h0003, 'h0005, 0, 0, "R9 compare keeps result");
    cyc(1, 12, 1, 'h1234, 'h1234, 0, 0, "R11 invalid code ignored");
    cyc(0, 0, 1, 'h1234, 'h1234, 0, 0, "R11 op_valid low ignored");
    cyc(0, 0, 0, 0, 0, 'b101, 0, "R10 set trap and direction");
    cyc(0, 0, 0, 0, 0, 'b010, 'b011, "R10 set beats clear");
    cyc(1, 2, 1, 'h0001, 'h0001, 0, 0, "R10 ops keep control flags, R12");
    cyc(0, 0, 0, 0, 0, 0, 'b111, "R10 clear all");

    for (int n = 0; n < 400; n++) begin
      cyc(1, $urandom_range(0, 11), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 'hFFFF)), int'($urandom_range(0, 'hFFFF)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
          "R2/R3/R4/R5/R6/R12 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule